// File: doc/BRIEF.md
# Indexed Configuration Register File

This block keeps the general-purpose setup registers of a disk host adapter behind a pair of I/O ports. Software first writes an 8-bit register index to the index port and then reads or writes the selected register through the data port. The index stays in place, so the same register can be accessed repeatedly. The register contents drive the transfer timing logic through dedicated output ports.

Four strap inputs are captured while reset is asserted. They move the port pair to an alternate address, supply a 2-bit device identifier, set the polarity of the host interrupt, and enable or disable disk transfers. The disk interrupt is passed to the host combinationally, either unchanged or inverted. A synchronised rising edge of the disk interrupt sets a status bit, and reading the status register clears that bit.

The index logic is a two-state machine. ST_NO_INDEX is entered at reset. In this state, data-port accesses are ignored and read 00h. The transition T_LOAD_INDEX is taken on any write to the index port and leads to ST_INDEXED. In ST_INDEXED, the transition T_HOLD keeps the machine there for every later cycle until reset.

Top module: `cfg_idx_regfile`

## Requirements
- R1: With the relocation strap latched at 0, the index port is I/O address 0B4h and the data port is 0B8h. With it latched at 1, the ports are 034h and 038h. Any other address (including the pair not selected) is ignored on writes and returns 00h on reads.
- R2: A write to the index port stores the 8-bit index, and a read of the index port returns it. Data-port writes made before the first index write since reset are ignored, and data-port reads in that state return 00h.
- R3: After reset, every register reads 00h, except index 59h, which reads 40h. The second-port enable is 0 and io_rdata is 00h.
- R4: Indexes 51h to 56h, 58h and 59h are full 8-bit read/write registers. Their values appear on ctrl_q, cmd_tim_q, d0_setup_q, d0_act_q, d1_setup_q, d1_act_q, gen2_q and burst_len_q, in that index order.
- R5: Index 50h reads bits 4:3 as the device ID latched from the straps. Bits 7:5, 1 and 0 read 0.
- R6: A rising edge of disk_irq, after a two-flop synchroniser, sets bit 2 of index 50h. A data read of index 50h returns the bit and then clears it; a new edge in the same cycle wins. A falling edge of disk_irq does not set the bit.
- R7: Bit 0 written at index 50h or at index 57h sets second_port_en. It reads back only as bit 0 of index 57h. Bits 7:1 of index 57h read 0.
- R8: host_irq equals disk_irq when the polarity strap was latched at 1, and equals the inverse of disk_irq when it was latched at 0, with no clock delay.
- R9: Straps are sampled on every clock edge while reset is high, so the values of the last reset cycle are held. The straps are ignored afterwards. xfer_enable reports the latched enable strap, and register access works whatever its value.
- R10: Data reads of an unimplemented index return 00h, and writes to such an index change no register.
- R11: io_rdata is loaded on the clock edge that samples io_rd high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset; straps are sampled while it is high |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| strap_relocate | input | 1 | Selects the alternate port pair |
| strap_dev_id | input | 2 | Device identifier strap |
| strap_irq_follow | input | 1 | 1: host interrupt follows disk interrupt; 0: inverted |
| strap_enable | input | 1 | Disk transfer enable strap |
| disk_irq | input | 1 | Interrupt from the drives |
| host_irq | output | 1 | Interrupt to the host |
| xfer_enable | output | 1 | Latched transfer enable |
| second_port_en | output | 1 | Second drive port enable |
| ctrl_q | output | 8 | Register at index 51h |
| cmd_tim_q | output | 8 | Register at index 52h |
| d0_setup_q | output | 8 | Register at index 53h |
| d0_act_q | output | 8 | Register at index 54h |
| d1_setup_q | output | 8 | Register at index 55h |
| d1_act_q | output | 8 | Register at index 56h |
| gen2_q | output | 8 | Register at index 58h |
| burst_len_q | output | 8 | Register at index 59h |

## Verification
The hardest situation to create is a strap whose latched value differs from the value it had earlier in the same reset pulse. The bench changes all four straps midway through a reset, and changes them again after reset is released. It then checks the relocated ports, the device ID, the interrupt polarity and the transfer enable against the values present in the last reset cycle only. The read-to-clear status bit is the second hard case. It is reached by raising disk_irq, waiting out the synchroniser, and reading index 50h twice, so that the first read shows the bit and the second read shows it cleared.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;

    typedef enum logic {
        ST_NO_INDEX,
        ST_INDEXED
    } acc_state_e;

    localparam logic [7:0] IDX_STATUS = 8'h50;
    localparam logic [7:0] IDX_PORT2  = 8'h57;
    localparam int         NSLOT      = 8;
    localparam int         SLOT_W     = $clog2(NSLOT) + 1;
    localparam int         BURST_SLOT = NSLOT - 1;
    localparam logic [SLOT_W-1:0] NO_SLOT = '1;

    // Plain storage slots: 51h..56h -> 0..5, 58h -> 6, 59h -> 7
    function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] idx);
        logic [7:0] off;
        if (idx >= 8'h51 && idx <= 8'h56) begin
            off = idx - 8'h51;
            return off[SLOT_W-1:0];
        end else if (idx == 8'h58 || idx == 8'h59) begin
            off = idx - 8'h52;
            return off[SLOT_W-1:0];
        end
        return NO_SLOT;
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] IDX_MAIN  = 'h0B4,
    parameter logic [ADDR_W-1:0] DATA_MAIN = 'h0B8,
    parameter logic [ADDR_W-1:0] IDX_ALT   = 'h034,
    parameter logic [ADDR_W-1:0] DATA_ALT  = 'h038
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              relocate,
    output logic              hit_index,
    output logic              hit_data
);

    always_comb begin
        if (relocate) begin
            hit_index = (addr == IDX_ALT);
            hit_data  = (addr == DATA_ALT);
        end else begin
            hit_index = (addr == IDX_MAIN);
            hit_data  = (addr == DATA_MAIN);
        end
    end

endmodule

// File: rtl/cfg_access_fsm.sv
module cfg_access_fsm
    import cfg_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_index,
    input  logic [7:0] wdata,
    output logic [7:0] index_q,
    output logic       indexed
);

    acc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_NO_INDEX;
        else     state_q <= state_d;
    end

    // next state: T_LOAD_INDEX, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NO_INDEX: if (wr_index) state_d = ST_INDEXED;
            ST_INDEXED:  state_d = ST_INDEXED;
        endcase
    end

    // outputs
    always_comb begin
        indexed = 1'b0;
        unique case (state_q)
            ST_NO_INDEX: indexed = 1'b0;
            ST_INDEXED:  indexed = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           index_q <= 8'h00;
        else if (wr_index) index_q <= wdata;
    end

endmodule

// File: rtl/cfg_irq_path.sv
module cfg_irq_path #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic disk_irq,
    input  logic follow,
    input  logic clr,
    output logic host_irq,
    output logic pending
);

    logic [SYNC_STAGES:0] chain_q;
    logic                 rise;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], disk_irq};
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst)       pending <= 1'b0;
        else if (rise) pending <= 1'b1;
        else if (clr)  pending <= 1'b0;
    end

    assign host_irq = follow ? disk_irq : ~disk_irq;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_regs_pkg::*;
#(
    parameter logic [7:0] BURST_RST = 8'h40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic       irq_pending,
    input  logic [1:0] dev_id,
    output logic [7:0] rd_val,
    output logic [7:0] plain_q [NSLOT],
    output logic       port2_en
);

    logic [SLOT_W-1:0] slot;
    assign slot = slot_of(idx);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [7:0] RST_VAL = (s == BURST_SLOT) ? BURST_RST : 8'h00;
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[s] <= RST_VAL;
            else if (wr_en && slot == SLOT_W'(s))
                plain_q[s] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            port2_en <= 1'b0;
        else if (wr_en && (idx == IDX_STATUS || idx == IDX_PORT2))
            port2_en <= wdata[0];
    end

    always_comb begin
        if (slot != NO_SLOT)
            rd_val = plain_q[slot[SLOT_W-2:0]];
        else if (idx == IDX_STATUS)
            rd_val = {3'b000, dev_id, irq_pending, 2'b00};
        else if (idx == IDX_PORT2)
            rd_val = {7'b0, port2_en};
        else
            rd_val = 8'h00;
    end

endmodule

// File: rtl/cfg_idx_regfile.sv
module cfg_idx_regfile
    import cfg_regs_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] IDX_MAIN    = 'h0B4,
    parameter logic [ADDR_W-1:0] DATA_MAIN   = 'h0B8,
    parameter logic [ADDR_W-1:0] IDX_ALT     = 'h034,
    parameter logic [ADDR_W-1:0] DATA_ALT    = 'h038,
    parameter logic [7:0]        BURST_RST   = 8'h40,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic              strap_relocate,
    input  logic [1:0]        strap_dev_id,
    input  logic              strap_irq_follow,
    input  logic              strap_enable,
    input  logic              disk_irq,
    output logic              host_irq,
    output logic              xfer_enable,
    output logic              second_port_en,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        cmd_tim_q,
    output logic [7:0]        d0_setup_q,
    output logic [7:0]        d0_act_q,
    output logic [7:0]        d1_setup_q,
    output logic [7:0]        d1_act_q,
    output logic [7:0]        gen2_q,
    output logic [7:0]        burst_len_q
);

    logic       reloc_q, follow_q, enable_q;
    logic [1:0] dev_id_q;
    logic       hit_index, hit_data, indexed;
    logic [7:0] index_q, bank_rd;
    logic       irq_clr, irq_pending;
    logic [7:0] plain_q [NSLOT];

    // straps follow the pins while reset is high; last reset cycle wins
    always_ff @(posedge clk) begin
        if (rst) begin
            reloc_q  <= strap_relocate;
            follow_q <= strap_irq_follow;
            enable_q <= strap_enable;
            dev_id_q <= strap_dev_id;
        end
    end

    cfg_port_decode #(
        .ADDR_W(ADDR_W), .IDX_MAIN(IDX_MAIN), .DATA_MAIN(DATA_MAIN),
        .IDX_ALT(IDX_ALT), .DATA_ALT(DATA_ALT)
    ) u_dec (
        .addr(io_addr), .relocate(reloc_q),
        .hit_index(hit_index), .hit_data(hit_data)
    );

    cfg_access_fsm u_fsm (
        .clk(clk), .rst(rst), .wr_index(io_wr & hit_index),
        .wdata(io_wdata), .index_q(index_q), .indexed(indexed)
    );

    assign irq_clr = io_rd & hit_data & indexed & (index_q == IDX_STATUS);

    cfg_irq_path #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk(clk), .rst(rst), .disk_irq(disk_irq), .follow(follow_q),
        .clr(irq_clr), .host_irq(host_irq), .pending(irq_pending)
    );

    cfg_reg_bank #(.BURST_RST(BURST_RST)) u_bank (
        .clk(clk), .rst(rst), .wr_en(io_wr & hit_data & indexed),
        .idx(index_q), .wdata(io_wdata), .irq_pending(irq_pending),
        .dev_id(dev_id_q), .rd_val(bank_rd), .plain_q(plain_q),
        .port2_en(second_port_en)
    );

    always_ff @(posedge clk) begin
        if (rst)
            io_rdata <= 8'h00;
        else if (io_rd) begin
            if (hit_index)              io_rdata <= index_q;
            else if (hit_data && indexed) io_rdata <= bank_rd;
            else                        io_rdata <= 8'h00;
        end
    end

    assign xfer_enable = enable_q;
    assign ctrl_q      = plain_q[0];
    assign cmd_tim_q   = plain_q[1];
    assign d0_setup_q  = plain_q[2];
    assign d0_act_q    = plain_q[3];
    assign d1_setup_q  = plain_q[4];
    assign d1_act_q    = plain_q[5];
    assign gen2_q      = plain_q[6];
    assign burst_len_q = plain_q[7];

endmodule

// File: rtl/cfg_idx_regfile_chk.sv
module cfg_idx_regfile_chk #(
    parameter logic [7:0] BURST_RST = 8'h40
) (
    input logic       clk,
    input logic       rst,
    input logic       io_rd,
    input logic [7:0] io_rdata,
    input logic       disk_irq,
    input logic       host_irq,
    input logic       xfer_enable,
    input logic       indexed,
    input logic [7:0] ctrl_q,
    input logic [7:0] burst_len_q,
    input logic       irq_clr,
    input logic       irq_pending
);

    p_reset_vals_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (burst_len_q == BURST_RST && ctrl_q == 8'h00 && io_rdata == 8'h00));

    p_no_index_r2: assert property (@(posedge clk) disable iff (rst)
        !indexed |=> ($stable(burst_len_q) && $stable(ctrl_q)));

    p_fall_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_pending) |-> $past(irq_clr));

    p_polarity_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(host_irq ^ disk_irq));

    p_strap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(xfer_enable));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

endmodule

bind cfg_idx_regfile cfg_idx_regfile_chk #(.BURST_RST(BURST_RST)) chk_i (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_rdata(io_rdata),
    .disk_irq(disk_irq), .host_irq(host_irq), .xfer_enable(xfer_enable),
    .indexed(indexed), .ctrl_q(ctrl_q), .burst_len_q(burst_len_q),
    .irq_clr(irq_clr), .irq_pending(irq_pending)
);

// File: tb/cfg_idx_regfile_tb_top.sv
module cfg_idx_regfile_tb_top;

    localparam int NVEC = 28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic       strap_relocate = 1'b0, strap_irq_follow = 1'b1, strap_enable = 1'b1;
    logic [1:0] strap_dev_id = 2'b10;
    logic       disk_irq = 1'b0;
    logic       host_irq, xfer_enable, second_port_en;
    logic [7:0] ctrl_q, cmd_tim_q, d0_setup_q, d0_act_q, d1_setup_q, d1_act_q, gen2_q, burst_len_q;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_idx_regfile dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .strap_relocate(strap_relocate), .strap_dev_id(strap_dev_id),
        .strap_irq_follow(strap_irq_follow), .strap_enable(strap_enable),
        .disk_irq(disk_irq), .host_irq(host_irq), .xfer_enable(xfer_enable),
        .second_port_en(second_port_en), .ctrl_q(ctrl_q), .cmd_tim_q(cmd_tim_q),
        .d0_setup_q(d0_setup_q), .d0_act_q(d0_act_q), .d1_setup_q(d1_setup_q),
        .d1_act_q(d1_act_q), .gen2_q(gen2_q), .burst_len_q(burst_len_q)
    );

    // {write, requirement number, address, data-or-expected}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b1, 4'd2,  10'h0B4, 8'h51},
        {1'b0, 4'd2,  10'h0B4, 8'h51},
        {1'b1, 4'd4,  10'h0B8, 8'hA5},
        {1'b0, 4'd4,  10'h0B8, 8'hA5},
        {1'b1, 4'd3,  10'h0B4, 8'h59},
        {1'b0, 4'd3,  10'h0B8, 8'h40},
        {1'b1, 4'd4,  10'h0B8, 8'h3C},
        {1'b0, 4'd4,  10'h0B8, 8'h3C},
        {1'b1, 4'd4,  10'h0B4, 8'h52},
        {1'b1, 4'd4,  10'h0B8, 8'h5A},
        {1'b0, 4'd4,  10'h0B8, 8'h5A},
        {1'b1, 4'd4,  10'h0B4, 8'h51},
        {1'b0, 4'd4,  10'h0B8, 8'hA5},
        {1'b1, 4'd10, 10'h0B4, 8'h7F},
        {1'b1, 4'd10, 10'h0B8, 8'hFF},
        {1'b0, 4'd10, 10'h0B8, 8'h00},
        {1'b1, 4'd5,  10'h0B4, 8'h50},
        {1'b0, 4'd5,  10'h0B8, 8'h10},
        {1'b1, 4'd7,  10'h0B8, 8'h01},
        {1'b0, 4'd7,  10'h0B8, 8'h10},
        {1'b1, 4'd7,  10'h0B4, 8'h57},
        {1'b0, 4'd7,  10'h0B8, 8'h01},
        {1'b1, 4'd7,  10'h0B8, 8'hFE},
        {1'b0, 4'd7,  10'h0B8, 8'h00},
        {1'b0, 4'd1,  10'h0BC, 8'h00},
        {1'b1, 4'd1,  10'h034, 8'h58},
        {1'b0, 4'd1,  10'h0B4, 8'h57},
        {1'b0, 4'd1,  10'h038, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R3 rdata", io_rdata, 8'h00);
        check("R3 burst", burst_len_q, 8'h40);
        check("R3 ctrl", ctrl_q, 8'h00);
        check("R3 port2", {7'b0, second_port_en}, 8'h00);
        check("R9 xfer_en", {7'b0, xfer_enable}, 8'h01);
        check("R8 host_irq low", {7'b0, host_irq}, 8'h00);
        // R2: data port before any index write
        do_rd(10'h0B8, rd); check("R2 no-index read", rd, 8'h00);
        do_wr(10'h0B8, 8'h77);
        check("R2 no-index write", burst_len_q, 8'h40);
        check("R2 no-index write ctrl", ctrl_q, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22]) do_wr(VEC[i][17:8], VEC[i][7:0]);
            else begin
                do_rd(VEC[i][17:8], rd);
                check($sformatf("R%0d vector %0d", VEC[i][21:18], i), rd, VEC[i][7:0]);
            end
        end
        check("R4 ctrl_q", ctrl_q, 8'hA5);
        check("R4 cmd_tim_q", cmd_tim_q, 8'h5A);
        check("R4 burst_len_q", burst_len_q, 8'h3C);
        check("R10 no side effect", gen2_q, 8'h00);
        check("R7 port2 cleared", {7'b0, second_port_en}, 8'h00);

        // R7: write through 50h, read back through 57h
        do_wr(10'h0B4, 8'h50); do_wr(10'h0B8, 8'h01);
        check("R7 port2 via 50h", {7'b0, second_port_en}, 8'h01);
        do_wr(10'h0B4, 8'h57);
        do_rd(10'h0B8, rd); check("R7 readback 57h", rd, 8'h01);

        // R6 read-to-clear, R8 polarity
        do_wr(10'h0B4, 8'h50);
        @(negedge clk); disk_irq = 1'b1; #1;
        check("R8 follow high", {7'b0, host_irq}, 8'h01);
        repeat (5) @(negedge clk);
        do_rd(10'h0B8, rd); check("R6 pending set", rd, 8'h14);
        do_rd(10'h0B8, rd); check("R6 pending cleared", rd, 8'h10);
        repeat (3) @(negedge clk);
        check("R11 rdata held", io_rdata, 8'h10);
        disk_irq = 1'b0; #1;
        check("R8 follow low", {7'b0, host_irq}, 8'h00);
        repeat (5) @(negedge clk);
        do_rd(10'h0B8, rd); check("R6 falling edge no set", rd, 8'h10);

        // second reset: straps change mid-reset and after release
        @(negedge clk);
        rst = 1'b1; strap_relocate = 1'b0; strap_dev_id = 2'b11;
        strap_irq_follow = 1'b1; strap_enable = 1'b1;
        repeat (2) @(negedge clk);
        strap_relocate = 1'b1; strap_dev_id = 2'b01;
        strap_irq_follow = 1'b0; strap_enable = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        strap_relocate = 1'b0; strap_dev_id = 2'b11;
        strap_irq_follow = 1'b1; strap_enable = 1'b1;
        @(negedge clk);
        check("R9 xfer_en latched low", {7'b0, xfer_enable}, 8'h00);
        check("R8 inverted", {7'b0, host_irq}, 8'h01);
        check("R3 port2 after reset", {7'b0, second_port_en}, 8'h00);
        do_wr(10'h034, 8'h50);
        do_rd(10'h038, rd); check("R5 dev id relocated", rd, 8'h08);
        do_rd(10'h0B4, rd); check("R1 main pair ignored", rd, 8'h00);
        do_rd(10'h034, rd); check("R1 alt index read", rd, 8'h50);
        do_wr(10'h034, 8'h59);
        do_rd(10'h038, rd); check("R9 access while disabled", rd, 8'h40);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule